// File: doc/BRIEF.md
# NAND Bad Block Scanner and Remapper

This block runs once after power-up, ahead of any program or erase traffic, and surveys every block of a serial SLC NAND array that has 1024 blocks of 64 pages, each page holding 2048 data bytes followed by a 64-byte spare area. For each block it asks a flash access engine for two marker bytes of the block's first page: data byte 0 and spare byte 0 (column 2048). A block counts as good only when both read 0xFF.

Every bad block found below a reserved pool of replacement blocks at the top of the array gets an entry in a small remap table of at most 20 entries. Its replacement is the highest-numbered pool block that is neither bad nor already named by a table entry. Entries can be preloaded as occupied when a scan starts. Their contents are kept and honoured, and their slots and physical blocks are never handed out again. The table then serves a combinational lookup port that turns a logical page address into a physical one. The `done` output is the signal that program and erase commands may now be issued.

A page address is 16 bits: bits 15:6 are the block and bits 5:0 are the page within the block. The read port carries one request at a time. A request is a one-cycle pulse with a page and column, and the next request is not issued until the response-valid has returned one data byte.

Top module: `nand_bbscan`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `rd_req` are 0, and the lookup passes every address through unchanged with `lk_hit` = 0.
- R2: A scan reads every block in descending order from 1023 to 0. Each block gets two reads at page address {block, 6'b0}: first column 0, then column 2048.
- R3: At most one read is outstanding. `rd_req` is a single-cycle pulse, and it is not raised again until `rd_rvalid` has answered the previous one.
- R4: A block whose two marker bytes are both 0xFF is good and gets no table entry, so its lookups pass through.
- R5: A bad block below the pool (block < 1000 with the default 24-block pool) is mapped to the highest-numbered pool block that is good and not named as physical block by any valid entry. Any non-0xFF value in either marker byte makes the block bad.
- R6: Pool blocks (1000 to 1023 by default) are scanned first. A bad pool block is never handed out as a replacement, and pool blocks themselves are never remapped.
- R7: Slots set in `pre_mask` are loaded from `pre_log`/`pre_phys` (slot e in bits e*10 +: 10) when a scan starts. They are honoured by lookups, and their slots and physical blocks are excluded from allocation.
- R8: When a bad block needs a replacement but no slot or no usable pool block remains, `err` rises and stays high. Existing entries are kept unchanged, and the scan still runs to `done`.
- R9: The lookup compares the block field of `lk_addr` against all valid entries at once. On a hit, `lk_phys` carries the entry's physical block with page bits 5:0 unchanged and `lk_hit` = 1. On a miss, `lk_phys` equals `lk_addr` and `lk_hit` = 0.
- R10: A `start` pulse seen while idle or done begins a scan. `busy` is high during the scan, and `done` stays high afterwards until the next accepted start. A `start` pulse during a scan is ignored.
- R11: An accepted start clears `err`, the pool-bad record and all non-preloaded entries before the new scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan (pulse) |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan finished; program/erase allowed |
| err | output | 1 | Remap capacity exhausted during the scan |
| rd_req | output | 1 | Single-cycle page-read request |
| rd_page | output | 16 | Page address of the request, block in 15:6 |
| rd_col | output | 12 | Byte column of the request (0 or 2048) |
| rd_rvalid | input | 1 | Read response valid |
| rd_data | input | 8 | Read response byte |
| pre_mask | input | 20 | Preloaded-slot mask, sampled at start |
| pre_log | input | 200 | Preloaded logical blocks, 10 bits per slot |
| pre_phys | input | 200 | Preloaded physical blocks, 10 bits per slot |
| lk_addr | input | 16 | Logical page address to translate |
| lk_phys | output | 16 | Translated physical page address |
| lk_hit | output | 1 | Lookup matched a valid entry |

## Verification
The hardest states to reach from the ports are the two kinds of capacity exhaustion. In one, every table slot is taken while good spares remain. In the other, good spares run out while slots remain, and the block also has to skip bad pool blocks and spares already claimed by preloaded entries. The bench's read responder serves marker bytes from a per-block image that the stimulus fills. One scan holds 25 bad user blocks so the slots run out. Another marks 21 of the 24 pool blocks bad so the spares run out. A third mixes preloaded entries that point into the pool with bad pool blocks. Random bad-block placement fills in the rest, and every block is looked up against a model table built from the same image.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

   localparam logic [7:0] ERASED_BYTE = 8'hFF;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REQ_MAIN,
      ST_WAIT_MAIN,
      ST_REQ_SPARE,
      ST_WAIT_SPARE,
      ST_JUDGE,
      ST_DONE
   } scan_state_e;

endpackage

// File: rtl/bbs_remap_table.sv
module bbs_remap_table #(
   parameter int BLK_W       = 10,
   parameter int PG_W        = 6,
   parameter int ENTRIES     = 20,
   parameter int POOL_BLOCKS = 24,
   parameter int SLOT_W      = 5
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       load,
   input  logic [ENTRIES-1:0]         pre_mask,
   input  logic [ENTRIES*BLK_W-1:0]   pre_log,
   input  logic [ENTRIES*BLK_W-1:0]   pre_phys,
   input  logic                       wr_en,
   input  logic [SLOT_W-1:0]          wr_slot,
   input  logic [BLK_W-1:0]           wr_log,
   input  logic [BLK_W-1:0]           wr_phys,
   output logic                       slot_ok,
   output logic [SLOT_W-1:0]          slot_idx,
   output logic [POOL_BLOCKS-1:0]     pool_used,
   input  logic [BLK_W+PG_W-1:0]      lk_addr,
   output logic [BLK_W+PG_W-1:0]      lk_phys,
   output logic                       lk_hit
);

   localparam int NUM_BLOCKS = 1 << BLK_W;
   localparam int POOL_BASE  = NUM_BLOCKS - POOL_BLOCKS;

   logic [ENTRIES-1:0] vld_q;
   logic [BLK_W-1:0]   log_q  [ENTRIES];
   logic [BLK_W-1:0]   phys_q [ENTRIES];
   logic [ENTRIES-1:0] match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         for (int e = 0; e < ENTRIES; e++) begin
            log_q[e]  <= '0;
            phys_q[e] <= '0;
         end
      end else if (load) begin
         vld_q <= pre_mask;
         for (int e = 0; e < ENTRIES; e++) begin
            log_q[e]  <= pre_log[e*BLK_W +: BLK_W];
            phys_q[e] <= pre_phys[e*BLK_W +: BLK_W];
         end
      end else if (wr_en) begin
         vld_q[wr_slot]  <= 1'b1;
         log_q[wr_slot]  <= wr_log;
         phys_q[wr_slot] <= wr_phys;
      end
   end

   // lowest free slot
   always_comb begin
      slot_ok  = 1'b0;
      slot_idx = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (!vld_q[e]) begin
            slot_ok  = 1'b1;
            slot_idx = SLOT_W'(e);
         end
      end
   end

   // pool blocks already named by a valid entry
   always_comb begin
      pool_used = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         for (int p = 0; p < POOL_BLOCKS; p++) begin
            if (vld_q[e] && phys_q[e] == BLK_W'(POOL_BASE + p)) pool_used[p] = 1'b1;
         end
      end
   end

   // parallel compare, one comparator per entry
   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign match[e] = vld_q[e] && (log_q[e] == lk_addr[BLK_W+PG_W-1:PG_W]);
   end

   logic [BLK_W-1:0] hit_blk;
   always_comb begin
      hit_blk = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (match[e]) hit_blk = hit_blk | phys_q[e];
      end
   end

   assign lk_hit  = |match;
   assign lk_phys = lk_hit ? {hit_blk, lk_addr[PG_W-1:0]} : lk_addr;

endmodule

// File: rtl/bbs_spare_pick.sv
module bbs_spare_pick #(
   parameter int BLK_W       = 10,
   parameter int POOL_BLOCKS = 24,
   parameter bit DESCEND     = 1'b1
) (
   input  logic [POOL_BLOCKS-1:0] pool_bad,
   input  logic [POOL_BLOCKS-1:0] pool_used,
   output logic                   ok,
   output logic [BLK_W-1:0]       blk
);

   localparam int POOL_BASE = (1 << BLK_W) - POOL_BLOCKS;
   localparam int PI_W      = (POOL_BLOCKS > 1) ? $clog2(POOL_BLOCKS) : 1;

   logic [POOL_BLOCKS-1:0] avail;
   logic [PI_W-1:0]        sel;

   assign avail = ~(pool_bad | pool_used);

   if (DESCEND) begin : g_desc
      always_comb begin
         ok  = 1'b0;
         sel = '0;
         for (int i = 0; i < POOL_BLOCKS; i++) begin
            if (avail[i]) begin
               ok  = 1'b1;
               sel = PI_W'(i);
            end
         end
      end
   end else begin : g_asc
      always_comb begin
         ok  = 1'b0;
         sel = '0;
         for (int i = POOL_BLOCKS - 1; i >= 0; i--) begin
            if (avail[i]) begin
               ok  = 1'b1;
               sel = PI_W'(i);
            end
         end
      end
   end

   assign blk = BLK_W'(POOL_BASE) + BLK_W'(sel);

endmodule

// File: rtl/bbs_scan_ctrl.sv
module bbs_scan_ctrl
   import bbs_pkg::*;
#(
   parameter int BLK_W       = 10,
   parameter int PG_W        = 6,
   parameter int COL_W       = 12,
   parameter int SPARE_COL   = 2048,
   parameter int POOL_BLOCKS = 24,
   parameter int SLOT_W      = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   output logic                   busy,
   output logic                   done,
   output logic                   err,
   output logic                   rd_req,
   output logic [BLK_W+PG_W-1:0]  rd_page,
   output logic [COL_W-1:0]       rd_col,
   input  logic                   rd_rvalid,
   input  logic [7:0]             rd_data,
   output logic                   tbl_load,
   output logic                   tbl_wr,
   output logic [SLOT_W-1:0]      tbl_slot,
   output logic [BLK_W-1:0]       tbl_log,
   output logic [BLK_W-1:0]       tbl_phys,
   input  logic                   slot_ok,
   input  logic [SLOT_W-1:0]      slot_idx,
   input  logic                   spare_ok,
   input  logic [BLK_W-1:0]       spare_blk,
   output logic [POOL_BLOCKS-1:0] pool_bad
);

   localparam int NUM_BLOCKS = 1 << BLK_W;
   localparam int POOL_BASE  = NUM_BLOCKS - POOL_BLOCKS;
   localparam int PI_W       = (POOL_BLOCKS > 1) ? $clog2(POOL_BLOCKS) : 1;

   scan_state_e      st_q, st_d;
   logic [BLK_W-1:0] blk_q;
   logic             main_bad_q, spare_bad_q, err_q;
   logic             accept, blk_bad, in_pool, need_spare, can_alloc;
   logic [BLK_W-1:0] pool_off;

   assign accept     = start && (st_q == ST_IDLE || st_q == ST_DONE);
   assign blk_bad    = main_bad_q | spare_bad_q;
   assign in_pool    = blk_q >= BLK_W'(POOL_BASE);
   assign pool_off   = blk_q - BLK_W'(POOL_BASE);
   assign need_spare = (st_q == ST_JUDGE) && blk_bad && !in_pool;
   assign can_alloc  = slot_ok && spare_ok;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE, ST_DONE: if (start)     st_d = ST_REQ_MAIN;
         ST_REQ_MAIN:                     st_d = ST_WAIT_MAIN;
         ST_WAIT_MAIN:     if (rd_rvalid) st_d = ST_REQ_SPARE;
         ST_REQ_SPARE:                    st_d = ST_WAIT_SPARE;
         ST_WAIT_SPARE:    if (rd_rvalid) st_d = ST_JUDGE;
         ST_JUDGE:         st_d = (blk_q == '0) ? ST_DONE : ST_REQ_MAIN;
         default:                         st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         blk_q       <= '0;
         main_bad_q  <= 1'b0;
         spare_bad_q <= 1'b0;
         err_q       <= 1'b0;
         pool_bad    <= '0;
      end else begin
         st_q <= st_d;
         if (accept) begin
            blk_q    <= '1;
            err_q    <= 1'b0;
            pool_bad <= '0;
         end
         if (st_q == ST_WAIT_MAIN && rd_rvalid)  main_bad_q  <= (rd_data != ERASED_BYTE);
         if (st_q == ST_WAIT_SPARE && rd_rvalid) spare_bad_q <= (rd_data != ERASED_BYTE);
         if (st_q == ST_JUDGE) begin
            if (blk_bad && in_pool) pool_bad[pool_off[PI_W-1:0]] <= 1'b1;
            if (need_spare && !can_alloc) err_q <= 1'b1;
            if (blk_q != '0) blk_q <= blk_q - 1'b1;
         end
      end
   end

   assign busy     = !(st_q == ST_IDLE || st_q == ST_DONE);
   assign done     = (st_q == ST_DONE);
   assign err      = err_q;
   assign rd_req   = (st_q == ST_REQ_MAIN) || (st_q == ST_REQ_SPARE);
   assign rd_page  = {blk_q, {PG_W{1'b0}}};
   assign rd_col   = (st_q == ST_REQ_SPARE || st_q == ST_WAIT_SPARE) ? COL_W'(SPARE_COL) : '0;
   assign tbl_load = accept;
   assign tbl_wr   = need_spare && can_alloc;
   assign tbl_slot = slot_idx;
   assign tbl_log  = blk_q;
   assign tbl_phys = spare_blk;

endmodule

// File: rtl/nand_bbscan.sv
module nand_bbscan #(
   parameter int BLK_W         = 10,
   parameter int PG_W          = 6,
   parameter int COL_W         = 12,
   parameter int SPARE_COL     = 2048,
   parameter int NUM_ENTRIES   = 20,
   parameter int POOL_BLOCKS   = 24,
   parameter bit ALLOC_DESCEND = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   output logic                         busy,
   output logic                         done,
   output logic                         err,
   output logic                         rd_req,
   output logic [BLK_W+PG_W-1:0]        rd_page,
   output logic [COL_W-1:0]             rd_col,
   input  logic                         rd_rvalid,
   input  logic [7:0]                   rd_data,
   input  logic [NUM_ENTRIES-1:0]       pre_mask,
   input  logic [NUM_ENTRIES*BLK_W-1:0] pre_log,
   input  logic [NUM_ENTRIES*BLK_W-1:0] pre_phys,
   input  logic [BLK_W+PG_W-1:0]        lk_addr,
   output logic [BLK_W+PG_W-1:0]        lk_phys,
   output logic                         lk_hit
);

   localparam int NUM_BLOCKS = 1 << BLK_W;
   localparam int SLOT_W     = $clog2(NUM_ENTRIES);

   if (POOL_BLOCKS < 1 || POOL_BLOCKS >= NUM_BLOCKS) begin : g_chk_pool
      $error("POOL_BLOCKS must lie between 1 and the block count minus one");
   end
   if (NUM_ENTRIES < 2) begin : g_chk_entries
      $error("NUM_ENTRIES must be at least 2");
   end
   if (SPARE_COL < 1 || SPARE_COL >= (1 << COL_W)) begin : g_chk_col
      $error("SPARE_COL must fit the column field and be nonzero");
   end

   logic                   tbl_load, tbl_wr, slot_ok, spare_ok;
   logic [SLOT_W-1:0]      tbl_slot, slot_idx;
   logic [BLK_W-1:0]       tbl_log, tbl_phys, spare_blk;
   logic [POOL_BLOCKS-1:0] pool_bad, pool_used;

   bbs_scan_ctrl #(
      .BLK_W(BLK_W), .PG_W(PG_W), .COL_W(COL_W), .SPARE_COL(SPARE_COL),
      .POOL_BLOCKS(POOL_BLOCKS), .SLOT_W(SLOT_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .busy(busy), .done(done), .err(err),
      .rd_req(rd_req), .rd_page(rd_page), .rd_col(rd_col),
      .rd_rvalid(rd_rvalid), .rd_data(rd_data),
      .tbl_load(tbl_load), .tbl_wr(tbl_wr), .tbl_slot(tbl_slot),
      .tbl_log(tbl_log), .tbl_phys(tbl_phys),
      .slot_ok(slot_ok), .slot_idx(slot_idx),
      .spare_ok(spare_ok), .spare_blk(spare_blk),
      .pool_bad(pool_bad)
   );

   bbs_spare_pick #(
      .BLK_W(BLK_W), .POOL_BLOCKS(POOL_BLOCKS), .DESCEND(ALLOC_DESCEND)
   ) u_pick (
      .pool_bad(pool_bad), .pool_used(pool_used),
      .ok(spare_ok), .blk(spare_blk)
   );

   bbs_remap_table #(
      .BLK_W(BLK_W), .PG_W(PG_W), .ENTRIES(NUM_ENTRIES),
      .POOL_BLOCKS(POOL_BLOCKS), .SLOT_W(SLOT_W)
   ) u_tbl (
      .clk(clk), .rst_n(rst_n), .load(tbl_load),
      .pre_mask(pre_mask), .pre_log(pre_log), .pre_phys(pre_phys),
      .wr_en(tbl_wr), .wr_slot(tbl_slot), .wr_log(tbl_log), .wr_phys(tbl_phys),
      .slot_ok(slot_ok), .slot_idx(slot_idx), .pool_used(pool_used),
      .lk_addr(lk_addr), .lk_phys(lk_phys), .lk_hit(lk_hit)
   );

endmodule

// File: rtl/nand_bbscan_chk.sv
module nand_bbscan_chk #(
   parameter int BLK_W     = 10,
   parameter int PG_W      = 6,
   parameter int COL_W     = 12,
   parameter int SPARE_COL = 2048
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  start,
   input logic                  busy,
   input logic                  done,
   input logic                  err,
   input logic                  rd_req,
   input logic [BLK_W+PG_W-1:0] rd_page,
   input logic [COL_W-1:0]      rd_col,
   input logic                  rd_rvalid,
   input logic [BLK_W+PG_W-1:0] lk_addr,
   input logic [BLK_W+PG_W-1:0] lk_phys,
   input logic                  lk_hit
);

   logic outstanding;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         outstanding <= 1'b0;
      else if (rd_req)    outstanding <= 1'b1;
      else if (rd_rvalid) outstanding <= 1'b0;
   end

   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> !outstanding); // R3
   AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req); // R3
   AST_MARKER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> ((rd_col == '0 || rd_col == COL_W'(SPARE_COL)) && rd_page[PG_W-1:0] == '0)); // R2
   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !rd_req); // R1
   AST_MISS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> lk_phys == lk_addr); // R9
   AST_HIT_PAGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> lk_phys[PG_W-1:0] == lk_addr[PG_W-1:0]); // R9
   AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done)); // R10
   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done); // R10
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err && busy) |=> err); // R8

endmodule

bind nand_bbscan nand_bbscan_chk #(
   .BLK_W(BLK_W), .PG_W(PG_W), .COL_W(COL_W), .SPARE_COL(SPARE_COL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .err(err),
   .rd_req(rd_req), .rd_page(rd_page), .rd_col(rd_col), .rd_rvalid(rd_rvalid),
   .lk_addr(lk_addr), .lk_phys(lk_phys), .lk_hit(lk_hit)
);

// File: tb/sim_nand_bbscan.sv
`timescale 1ns/1ps
module sim_nand_bbscan;

   localparam int NB   = 1024;
   localparam int POOL = 24;
   localparam int BASE = NB - POOL;
   localparam int NE   = 20;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         busy, done, err, rd_req, lk_hit;
   logic [15:0]  rd_page, lk_phys;
   logic [15:0]  lk_addr = '0;
   logic [11:0]  rd_col;
   logic         rd_rvalid;
   logic [7:0]   rd_data;
   logic [NE-1:0]    pre_mask = '0;
   logic [NE*10-1:0] pre_log  = '0;
   logic [NE*10-1:0] pre_phys = '0;

   always #2 clk = ~clk;

   nand_bbscan u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .err(err),
      .rd_req(rd_req), .rd_page(rd_page), .rd_col(rd_col),
      .rd_rvalid(rd_rvalid), .rd_data(rd_data),
      .pre_mask(pre_mask), .pre_log(pre_log), .pre_phys(pre_phys),
      .lk_addr(lk_addr), .lk_phys(lk_phys), .lk_hit(lk_hit)
   );

   int n_checks = 0;
   int n_fail   = 0;

   logic [7:0] mk_main  [NB];
   logic [7:0] mk_spare [NB];
   bit         is_pre   [NB];
   int         exp_map  [NB];
   bit         exp_err;

   int rd_count, seq_bad, viol, exp_blk;
   bit exp_sp;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // read responder and request-order monitor
   initial begin
      bit pend;
      int lat, cblk;
      bit csp;
      rd_rvalid = 1'b0;
      rd_data   = 8'h00;
      pend = 1'b0; lat = 0; cblk = 0; csp = 1'b0;
      forever begin
         @(negedge clk);
         if (rd_rvalid) rd_rvalid = 1'b0;
         if (rd_req) begin
            if (pend) viol++;
            pend = 1'b1;
            lat  = $urandom_range(1, 3);
            cblk = int'(rd_page[15:6]);
            csp  = (rd_col == 12'd2048);
            if (rd_page != {exp_blk[9:0], 6'b0} || rd_col != (exp_sp ? 12'd2048 : 12'd0))
               seq_bad++;
            if (exp_sp) exp_blk--;
            exp_sp = !exp_sp;
            rd_count++;
         end else if (pend) begin
            lat--;
            if (lat == 0) begin
               rd_rvalid = 1'b1;
               rd_data   = csp ? mk_spare[cblk] : mk_main[cblk];
               pend      = 1'b0;
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_checks, n_fail);
      $finish;
   end

   task automatic clear_world();
      for (int b = 0; b < NB; b++) begin
         mk_main[b]  = 8'hFF;
         mk_spare[b] = 8'hFF;
         is_pre[b]   = 1'b0;
      end
      pre_mask = '0;
      pre_log  = '0;
      pre_phys = '0;
   endtask

   function automatic bit blk_bad(input int b);
      return (mk_main[b] != 8'hFF) || (mk_spare[b] != 8'hFF);
   endfunction

   task automatic mark_bad(input int b);
      int mode;
      mode = $urandom_range(0, 2);
      if (mode != 1) mk_main[b]  = 8'($urandom_range(0, 254));
      if (mode != 0) mk_spare[b] = 8'($urandom_range(0, 254));
   endtask

   task automatic rand_bad_users(input int n);
      int got;
      got = 0;
      while (got < n) begin
         int b;
         b = $urandom_range(1, BASE - 2);
         if (!blk_bad(b) && !is_pre[b]) begin
            mark_bad(b);
            got++;
         end
      end
   endtask

   task automatic preload(input int slot, input int lg, input int ph);
      pre_mask[slot]         = 1'b1;
      pre_log[slot*10 +: 10] = 10'(lg);
      pre_phys[slot*10 +: 10] = 10'(ph);
      is_pre[lg] = 1'b1;
   endtask

   task automatic build_model();
      int used_slots, s;
      bit pbad [POOL];
      bit pused [POOL];
      used_slots = 0;
      exp_err = 1'b0;
      for (int b = 0; b < NB; b++) exp_map[b] = -1;
      for (int i = 0; i < POOL; i++) begin pbad[i] = 1'b0; pused[i] = 1'b0; end
      for (int e = 0; e < NE; e++) begin
         if (pre_mask[e]) begin
            int lg, ph;
            lg = int'(pre_log[e*10 +: 10]);
            ph = int'(pre_phys[e*10 +: 10]);
            used_slots++;
            exp_map[lg] = ph;
            if (ph >= BASE) pused[ph - BASE] = 1'b1;
         end
      end
      for (int b = NB - 1; b >= 0; b--) begin
         if (b >= BASE) begin
            if (blk_bad(b)) pbad[b - BASE] = 1'b1;
         end else if (blk_bad(b)) begin
            s = -1;
            for (int i = POOL - 1; i >= 0; i--)
               if (s < 0 && !pbad[i] && !pused[i]) s = i;
            if (used_slots < NE && s >= 0) begin
               exp_map[b] = BASE + s;
               pused[s] = 1'b1;
               used_slots++;
            end else begin
               exp_err = 1'b1;
            end
         end
      end
   endtask

   task automatic run_scan(input bit poke_mid);
      rd_count = 0; seq_bad = 0; viol = 0; exp_blk = NB - 1; exp_sp = 1'b0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(busy && !done, "R10", "busy after start", {busy, done}, 2'b10);
      chk(err == 1'b0, "R11", "err cleared at start", err, 0);
      if (poke_mid) begin
         repeat (150) @(negedge clk);
         start = 1'b1;
         @(negedge clk); start = 1'b0;
      end
      while (!done) @(negedge clk);
      chk(rd_count == 2 * NB, "R2", "read count", rd_count, 2 * NB);
      chk(seq_bad == 0, "R2", "read order errors (R10 start ignored)", seq_bad, 0);
      chk(viol == 0, "R3", "outstanding violations", viol, 0);
      chk(err == exp_err, "R8", "err flag", err, exp_err);
      repeat (5) @(negedge clk);
      chk(done && !busy, "R10", "done holds", {busy, done}, 2'b01);
   endtask

   task automatic check_map();
      for (int b = 0; b < NB; b++) begin
         int pg;
         logic [15:0] ex;
         bit eh;
         string tag;
         pg = $urandom_range(0, 63);
         @(negedge clk);
         lk_addr = {10'(b), 6'(pg)};
         #1;
         eh = (exp_map[b] >= 0);
         ex = eh ? {10'(exp_map[b]), 6'(pg)} : lk_addr;
         if (is_pre[b])            tag = "R7";
         else if (b >= BASE)       tag = "R6";
         else if (blk_bad(b))      tag = "R5/R9";
         else                      tag = "R4/R9";
         chk(lk_phys == ex && lk_hit == eh, tag, "lookup {hit,phys}", {lk_hit, lk_phys}, {eh, ex});
      end
   endtask

   initial begin
      clear_world();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      lk_addr = 16'hA5C3;
      #1;
      chk(!busy && !done && !err && !rd_req, "R1", "idle outputs", {busy, done, err, rd_req}, 0);
      chk(lk_phys == 16'hA5C3 && !lk_hit, "R1", "pass-through after reset", lk_phys, 16'hA5C3);

      // A: random bad user blocks, two bad pool blocks, boundary blocks, start poked mid-scan
      clear_world();
      mk_main[1023] = 8'h00;
      mk_spare[1020] = 8'h7E;
      mk_spare[0]   = 8'hFE;
      mk_main[BASE - 1] = 8'h00;
      rand_bad_users(8);
      build_model();
      run_scan(1'b1);
      check_map();

      // C: slot exhaustion
      clear_world();
      rand_bad_users(25);
      build_model();
      run_scan(1'b0);
      chk(err == 1'b1, "R8", "slot overflow flagged", err, 1);
      check_map();

      // B: preloaded entries into the pool, a bad pool block, error cleared by restart
      clear_world();
      preload(0, 5, 1023);
      preload(3, 17, 1010);
      preload(7, 400, 1022);
      mk_main[1021] = 8'h00;
      rand_bad_users(8);
      build_model();
      run_scan(1'b0);
      chk(err == 1'b0, "R11", "err low after clean rescan", err, 0);
      check_map();

      // D: spare exhaustion, most pool blocks bad
      clear_world();
      for (int b = BASE; b < BASE + 21; b++) mark_bad(b);
      rand_bad_users(5);
      build_model();
      run_scan(1'b0);
      chk(err == 1'b1, "R8", "spare overflow flagged", err, 1);
      check_map();

      $display("test done: total=%0d bad=%0d", n_checks, n_fail);
      $finish;
   end

endmodule